// File: doc/BRIEF.md
# Power-On Strap Capture and Configuration Decoder

This block sits between a clock generator's shared strap pads, its configuration byte registers and the output stage. While power-on reset is held, the pads are read as inputs: five frequency-select levels and one mode level are sampled every clock. When reset is released, the last sampled levels are frozen and the pads are handed over to output duty.

After that, the block merges the frozen strap values with six host-written configuration bytes. It produces the following outputs:

- the effective 5-bit frequency code, taken from either the straps or a software field;
- the spread-spectrum enable;
- a global tristate request;
- the individual output enable masks;
- readback copies of three bytes, in which the strap values appear inverted at fixed bit positions.

Every output is registered, so a new byte value shows up exactly one clock after it is presented.

The frozen mode strap selects the board flavour. A value of 1 means desktop: the dual-purpose pin 2 then acts as a reference clock output. A value of 0 means mobile: pin 2 then acts as the PCI stop input. The block reports this choice on `desktop_mode`.

Top module: `strap_cfg_decode`

## Requirements
- R1: While `por_active` is high the strap latch samples `strap_fs_pin` and `strap_mode_pin` on every clock. After `por_active` falls, later changes on those pins affect no output.
- R2: `pad_drive_en` is 0 while `por_active` is high. It becomes 1 one clock after `por_active` is seen low.
- R3: When `cfg_b0[3]` is 0, `freq_code` equals the latched strap code, with `strap_fs_pin[4]` as the MSB.
- R4: When `cfg_b0[3]` is 1, `freq_code` equals `{cfg_b0[2], cfg_b0[7:4]}`, with bit 2 as the MSB.
- R5: `spread_en` follows `cfg_b0[1]` and `all_tristate` follows `cfg_b0[0]`.
- R6: The readback bytes copy the host bytes, except at six positions that carry inverted latched straps:
  - `rb_b1[7]` = ~fs2, `rb_b1[6]` = ~fs4;
  - `rb_b3[7]` = ~mode, `rb_b3[6]` = ~fs0;
  - `rb_b4[3]` = ~fs1, `rb_b4[1]` = ~fs3.
- R7: Host values written to those six readback positions have no effect on the readback bytes.
- R8: `sdram_en[4g+k]` = `cfg_b3[g]` for group g in 0..2 and k in 0..3. `usb48_en` = `cfg_b3[5]` and `sio24_en` = `cfg_b3[4]`. A 1 lets the output run and a 0 holds it low.
- R9: The remaining enables map as follows, with the same polarity as R8:
  - `cpu_en` = `cfg_b1[1:0]`, `sdram_f_en` = `cfg_b1[3]`;
  - `pci_en` = `cfg_b2[4:0]`, `pci_free_en` = `cfg_b2[6]`;
  - `ref_en` = `cfg_b5[1:0]`, `apic_en` = `cfg_b5[4]`.
- R10: `desktop_mode` equals the latched mode strap. A value of 1 means pin 2 is a reference output; a value of 0 means it is the PCI stop input.
- R11: A change on any configuration byte reaches the outputs exactly one clock later, and never in the same cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_active | input | 1 | Power-on reset, active high; strap sampling window |
| strap_fs_pin | input | 5 | Frequency-select strap levels from the shared pads |
| strap_mode_pin | input | 1 | Mode strap level from its shared pad |
| cfg_b0 | input | 8 | Function and frequency byte |
| cfg_b1 | input | 8 | CPU enable byte |
| cfg_b2 | input | 8 | PCI enable byte |
| cfg_b3 | input | 8 | SDRAM and fixed-clock enable byte |
| cfg_b4 | input | 8 | Spare byte, used for readback only |
| cfg_b5 | input | 8 | Peripheral enable byte |
| pad_drive_en | output | 1 | Shared pads switch to output use |
| freq_code | output | 5 | Effective frequency select code |
| spread_en | output | 1 | Spread-spectrum enable |
| all_tristate | output | 1 | Tristate all outputs |
| desktop_mode | output | 1 | Latched mode strap (1 = desktop) |
| cpu_en | output | 2 | CPU clock enables |
| sdram_f_en | output | 1 | Free-running SDRAM clock enable |
| pci_en | output | 5 | Stoppable PCI clock enables |
| pci_free_en | output | 1 | Free-running PCI clock enable |
| sdram_en | output | 12 | SDRAM clock enables, four per group |
| usb48_en | output | 1 | 48 MHz output enable |
| sio24_en | output | 1 | 24 MHz output enable |
| ref_en | output | 2 | Reference clock enables |
| apic_en | output | 1 | Interrupt controller clock enable |
| rb_b1 | output | 8 | Readback of byte 1 with inverted straps merged |
| rb_b3 | output | 8 | Readback of byte 3 with inverted straps merged |
| rb_b4 | output | 8 | Readback of byte 4 with inverted straps merged |

## Verification
The bench changes the strap pins after power-on reset ends and checks that neither the frequency code nor the readback moves. A leaky latch would show up as a code that follows the pads.

It writes all-ones and all-zeros host values over the six readback positions and looks for the inverted strap levels there. A design with swapped positions or missing inversion would read back the wrong bits.

It walks `cfg_b0` patterns that flip the source select while the software field differs from the straps, which exposes a wrong MSB ordering or an inverted select. It also samples in the very cycle a byte changes and in the cycle after, to catch a combinational leak or an extra pipeline stage.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

  localparam int FS_W = 5;

  typedef struct packed {
    logic            mode;
    logic [FS_W-1:0] fs;
  } strap_t;

  // Software frequency field: byte 0 bit 2 is the MSB, bits 7..4 follow.
  function automatic logic [FS_W-1:0] sw_code(input logic [7:0] b0);
    return {b0[2], b0[7:4]};
  endfunction

  function automatic logic [7:0] merge_rb1(input logic [7:0] host, input strap_t s);
    logic [7:0] r;
    r    = host;
    r[7] = ~s.fs[2];
    r[6] = ~s.fs[4];
    return r;
  endfunction

  function automatic logic [7:0] merge_rb3(input logic [7:0] host, input strap_t s);
    logic [7:0] r;
    r    = host;
    r[7] = ~s.mode;
    r[6] = ~s.fs[0];
    return r;
  endfunction

  function automatic logic [7:0] merge_rb4(input logic [7:0] host, input strap_t s);
    logic [7:0] r;
    r    = host;
    r[3] = ~s.fs[1];
    r[1] = ~s.fs[3];
    return r;
  endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         por_active,
  input  logic [W-1:0] pins_in,
  output logic [W-1:0] latched,
  output logic         pad_drive_en
);

  // One capture flop per strap: it loads only inside the reset window.
  for (genvar i = 0; i < W; i++) begin : g_cap
    always_ff @(posedge clk) begin
      if (por_active) latched[i] <= pins_in[i];
    end
  end

  always_ff @(posedge clk) begin
    pad_drive_en <= !por_active;
  end

endmodule

// File: rtl/code_select.sv
module code_select
  import strap_cfg_pkg::*;
(
  input  logic            clk,
  input  logic [7:0]      cfg_b0,
  input  logic [FS_W-1:0] strap_fs,
  output logic [FS_W-1:0] freq_code,
  output logic            spread_en,
  output logic            all_tristate,
  output logic            sw_sel
);

  logic [FS_W-1:0] code_next;

  assign sw_sel    = cfg_b0[3];
  assign code_next = sw_sel ? sw_code(cfg_b0) : strap_fs;

  always_ff @(posedge clk) begin
    freq_code    <= code_next;
    spread_en    <= cfg_b0[1];
    all_tristate <= cfg_b0[0];
  end

endmodule

// File: rtl/enable_map.sv
module enable_map #(
  parameter int CPU_N     = 2,
  parameter int PCI_N     = 5,
  parameter int REF_N     = 2,
  parameter int SDR_GRP   = 3,
  parameter int SDR_PER   = 4,
  localparam int SDR_N    = SDR_GRP * SDR_PER
) (
  input  logic             clk,
  input  logic [7:0]       cfg_b1,
  input  logic [7:0]       cfg_b2,
  input  logic [7:0]       cfg_b3,
  input  logic [7:0]       cfg_b5,
  output logic [CPU_N-1:0] cpu_en,
  output logic             sdram_f_en,
  output logic [PCI_N-1:0] pci_en,
  output logic             pci_free_en,
  output logic [SDR_N-1:0] sdram_en,
  output logic             usb48_en,
  output logic             sio24_en,
  output logic [REF_N-1:0] ref_en,
  output logic             apic_en
);

  logic [SDR_N-1:0] sdram_next;

  // Each group bit of byte 3 fans out to its group of SDRAM clocks.
  for (genvar g = 0; g < SDR_GRP; g++) begin : g_grp
    for (genvar k = 0; k < SDR_PER; k++) begin : g_bit
      assign sdram_next[g*SDR_PER + k] = cfg_b3[g];
    end
  end

  always_ff @(posedge clk) begin
    cpu_en      <= cfg_b1[CPU_N-1:0];
    sdram_f_en  <= cfg_b1[3];
    pci_en      <= cfg_b2[PCI_N-1:0];
    pci_free_en <= cfg_b2[6];
    sdram_en    <= sdram_next;
    usb48_en    <= cfg_b3[5];
    sio24_en    <= cfg_b3[4];
    ref_en      <= cfg_b5[REF_N-1:0];
    apic_en     <= cfg_b5[4];
  end

  logic unused_bits;
  assign unused_bits = ^{cfg_b1, cfg_b2, cfg_b3, cfg_b5};

endmodule

// File: rtl/readback_merge.sv
module readback_merge
  import strap_cfg_pkg::*;
(
  input  logic       clk,
  input  strap_t     strap,
  input  logic [7:0] cfg_b1,
  input  logic [7:0] cfg_b3,
  input  logic [7:0] cfg_b4,
  output logic [7:0] rb_b1,
  output logic [7:0] rb_b3,
  output logic [7:0] rb_b4,
  output logic       desktop_mode
);

  always_ff @(posedge clk) begin
    rb_b1        <= merge_rb1(cfg_b1, strap);
    rb_b3        <= merge_rb3(cfg_b3, strap);
    rb_b4        <= merge_rb4(cfg_b4, strap);
    desktop_mode <= strap.mode;
  end

endmodule

// File: rtl/strap_cfg_decode.sv
module strap_cfg_decode
  import strap_cfg_pkg::*;
#(
  parameter int CPU_N   = 2,
  parameter int PCI_N   = 5,
  parameter int REF_N   = 2,
  parameter int SDR_GRP = 3,
  parameter int SDR_PER = 4,
  localparam int SDR_N  = SDR_GRP * SDR_PER,
  localparam int ST_W   = FS_W + 1
) (
  input  logic             clk,
  input  logic             por_active,
  input  logic [FS_W-1:0]  strap_fs_pin,
  input  logic             strap_mode_pin,
  input  logic [7:0]       cfg_b0,
  input  logic [7:0]       cfg_b1,
  input  logic [7:0]       cfg_b2,
  input  logic [7:0]       cfg_b3,
  input  logic [7:0]       cfg_b4,
  input  logic [7:0]       cfg_b5,
  output logic             pad_drive_en,
  output logic [FS_W-1:0]  freq_code,
  output logic             spread_en,
  output logic             all_tristate,
  output logic             desktop_mode,
  output logic [CPU_N-1:0] cpu_en,
  output logic             sdram_f_en,
  output logic [PCI_N-1:0] pci_en,
  output logic             pci_free_en,
  output logic [SDR_N-1:0] sdram_en,
  output logic             usb48_en,
  output logic             sio24_en,
  output logic [REF_N-1:0] ref_en,
  output logic             apic_en,
  output logic [7:0]       rb_b1,
  output logic [7:0]       rb_b3,
  output logic [7:0]       rb_b4
);

  strap_t          strap_q;
  logic [ST_W-1:0] strap_bits;
  logic [FS_W-1:0] strap_fs_w;
  logic            sw_sel_w;

  strap_latch #(.W(ST_W)) u_latch (
    .clk          (clk),
    .por_active   (por_active),
    .pins_in      ({strap_mode_pin, strap_fs_pin}),
    .latched      (strap_bits),
    .pad_drive_en (pad_drive_en)
  );

  assign strap_q    = strap_t'(strap_bits);
  assign strap_fs_w = strap_q.fs;

  code_select u_code (
    .clk          (clk),
    .cfg_b0       (cfg_b0),
    .strap_fs     (strap_fs_w),
    .freq_code    (freq_code),
    .spread_en    (spread_en),
    .all_tristate (all_tristate),
    .sw_sel       (sw_sel_w)
  );

  enable_map #(
    .CPU_N(CPU_N), .PCI_N(PCI_N), .REF_N(REF_N),
    .SDR_GRP(SDR_GRP), .SDR_PER(SDR_PER)
  ) u_en (
    .clk         (clk),
    .cfg_b1      (cfg_b1),
    .cfg_b2      (cfg_b2),
    .cfg_b3      (cfg_b3),
    .cfg_b5      (cfg_b5),
    .cpu_en      (cpu_en),
    .sdram_f_en  (sdram_f_en),
    .pci_en      (pci_en),
    .pci_free_en (pci_free_en),
    .sdram_en    (sdram_en),
    .usb48_en    (usb48_en),
    .sio24_en    (sio24_en),
    .ref_en      (ref_en),
    .apic_en     (apic_en)
  );

  readback_merge u_rb (
    .clk          (clk),
    .strap        (strap_q),
    .cfg_b1       (cfg_b1),
    .cfg_b3       (cfg_b3),
    .cfg_b4       (cfg_b4),
    .rb_b1        (rb_b1),
    .rb_b3        (rb_b3),
    .rb_b4        (rb_b4),
    .desktop_mode (desktop_mode)
  );

endmodule

// File: rtl/strap_cfg_checker.sv
module strap_cfg_checker (
  input logic       clk,
  input logic       por_active,
  input logic       pad_drive_en,
  input logic [7:0] cfg_b0,
  input logic [7:0] cfg_b3,
  input logic [4:0] freq_code,
  input logic [4:0] strap_fs_w,
  input logic       sw_sel,
  input logic       spread_en,
  input logic       desktop_mode,
  input logic [7:0] rb_b1,
  input logic [7:0] rb_b3,
  input logic [7:0] rb_b4,
  input logic       sdram_en0
);

  a_r2_pads_after_por: assert property (@(posedge clk) disable iff (por_active)
    !por_active |=> pad_drive_en);

  a_r3_hw_code: assert property (@(posedge clk) disable iff (por_active)
    (pad_drive_en && !sw_sel) |=> (freq_code == $past(strap_fs_w)));

  a_r4_sw_code: assert property (@(posedge clk) disable iff (por_active)
    (pad_drive_en && cfg_b0[3]) |=> (freq_code == {$past(cfg_b0[2]), $past(cfg_b0[7:4])}));

  a_r5_spread: assert property (@(posedge clk) disable iff (por_active)
    pad_drive_en |=> (spread_en == $past(cfg_b0[1])));

  a_r6_mode_inverted: assert property (@(posedge clk) disable iff (por_active)
    (pad_drive_en && $past(pad_drive_en)) |-> (rb_b3[7] != desktop_mode));

  a_r7_readback_frozen: assert property (@(posedge clk) disable iff (por_active)
    (pad_drive_en && $past(pad_drive_en)) |->
      ($stable(rb_b1[7:6]) && $stable(rb_b3[7:6]) && $stable(rb_b4[3]) && $stable(rb_b4[1])));

  a_r8_sdram_group: assert property (@(posedge clk) disable iff (por_active)
    pad_drive_en |=> (sdram_en0 == $past(cfg_b3[0])));

endmodule

bind strap_cfg_decode strap_cfg_checker chk_i (
  .clk          (clk),
  .por_active   (por_active),
  .pad_drive_en (pad_drive_en),
  .cfg_b0       (cfg_b0),
  .cfg_b3       (cfg_b3),
  .freq_code    (freq_code),
  .strap_fs_w   (strap_fs_w),
  .sw_sel       (sw_sel_w),
  .spread_en    (spread_en),
  .desktop_mode (desktop_mode),
  .rb_b1        (rb_b1),
  .rb_b3        (rb_b3),
  .rb_b4        (rb_b4),
  .sdram_en0    (sdram_en[0])
);

// File: tb/strap_cfg_decode_tb_top.sv
module strap_cfg_decode_tb_top;

  logic        clk = 1'b0;
  logic        por_active;
  logic [4:0]  strap_fs_pin;
  logic        strap_mode_pin;
  logic [7:0]  cfg_b0, cfg_b1, cfg_b2, cfg_b3, cfg_b4, cfg_b5;
  logic        pad_drive_en, spread_en, all_tristate, desktop_mode;
  logic [4:0]  freq_code;
  logic [1:0]  cpu_en, ref_en;
  logic        sdram_f_en, pci_free_en, usb48_en, sio24_en, apic_en;
  logic [4:0]  pci_en;
  logic [11:0] sdram_en;
  logic [7:0]  rb_b1, rb_b3, rb_b4;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  strap_cfg_decode dut_i (
    .clk(clk), .por_active(por_active), .strap_fs_pin(strap_fs_pin),
    .strap_mode_pin(strap_mode_pin), .cfg_b0(cfg_b0), .cfg_b1(cfg_b1),
    .cfg_b2(cfg_b2), .cfg_b3(cfg_b3), .cfg_b4(cfg_b4), .cfg_b5(cfg_b5),
    .pad_drive_en(pad_drive_en), .freq_code(freq_code), .spread_en(spread_en),
    .all_tristate(all_tristate), .desktop_mode(desktop_mode), .cpu_en(cpu_en),
    .sdram_f_en(sdram_f_en), .pci_en(pci_en), .pci_free_en(pci_free_en),
    .sdram_en(sdram_en), .usb48_en(usb48_en), .sio24_en(sio24_en),
    .ref_en(ref_en), .apic_en(apic_en), .rb_b1(rb_b1), .rb_b3(rb_b3), .rb_b4(rb_b4)
  );

  // {cfg_b0, expected code, expected spread, expected tristate}; latched straps are 10110
  localparam logic [14:0] VEC [8] = '{
    {8'h00, 5'b10110, 1'b0, 1'b0},
    {8'h08, 5'b00000, 1'b0, 1'b0},
    {8'hFC, 5'b11111, 1'b0, 1'b0},
    {8'h5E, 5'b10101, 1'b1, 1'b0},
    {8'hA9, 5'b01010, 1'b0, 1'b1},
    {8'h33, 5'b10110, 1'b1, 1'b1},
    {8'h0C, 5'b10000, 1'b0, 1'b0},
    {8'hF7, 5'b10110, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    por_active = 1'b1;
    strap_fs_pin = 5'b00000; strap_mode_pin = 1'b0;
    cfg_b0 = 8'h00; cfg_b1 = 8'hFF; cfg_b2 = 8'hFF;
    cfg_b3 = 8'hFF; cfg_b4 = 8'hFF; cfg_b5 = 8'hFF;
    cyc(3);
    check("R2 pads held off during POR", pad_drive_en, 1'b0);
    strap_fs_pin = 5'b10110; strap_mode_pin = 1'b1;
    cyc(3);
    por_active = 1'b0;
    #1 check("R2 pads still off at release", pad_drive_en, 1'b0);
    cyc(1);
    check("R2 pads driven after POR", pad_drive_en, 1'b1);
    cyc(2);
    check("R10 desktop mode latched", desktop_mode, 1'b1);
    check("R6 rb_b1 host FF", rb_b1, 8'h3F);
    check("R6 rb_b3 host FF", rb_b3, 8'h7F);
    check("R6 rb_b4 host FF", rb_b4, 8'hF7);
    check("R3 hw code after POR", freq_code, 5'b10110);

    // R1: pins move after POR; nothing may follow them
    strap_fs_pin = 5'b01001; strap_mode_pin = 1'b0;
    cyc(3);
    check("R1 code frozen", freq_code, 5'b10110);
    check("R1 mode frozen", desktop_mode, 1'b1);
    check("R1 rb_b3 frozen", rb_b3, 8'h7F);

    // R7: host zeros over strap positions
    cfg_b1 = 8'h00; cfg_b3 = 8'h00; cfg_b4 = 8'h00;
    cyc(1);
    check("R7 rb_b1 host 00", rb_b1, 8'h00);
    check("R7 rb_b3 host 00", rb_b3, 8'h40);
    check("R7 rb_b4 host 00", rb_b4, 8'h02);

    // R3 R4 R5 vector walk
    for (int i = 0; i < 8; i++) begin
      cfg_b0 = VEC[i][14:7];
      cyc(1);
      check("R3/R4 code vector", freq_code, VEC[i][6:2]);
      check("R5 spread vector", spread_en, VEC[i][1]);
      check("R5 tristate vector", all_tristate, VEC[i][0]);
    end

    // R11: no change in the cycle presented, change one clock later
    cfg_b0 = 8'h48;
    #2 check("R11 no same-cycle change", freq_code, 5'b10110);
    cyc(1);
    check("R11 change after one clock", freq_code, 5'b00100);

    // R8 and R9 enables
    cfg_b3 = 8'b0010_0101; cfg_b1 = 8'h0A; cfg_b2 = 8'h4A; cfg_b5 = 8'h11;
    cyc(1);
    check("R8 sdram groups", sdram_en, 12'hF0F);
    check("R8 usb48", usb48_en, 1'b1);
    check("R8 sio24", sio24_en, 1'b0);
    check("R9 cpu_en", cpu_en, 2'b10);
    check("R9 sdram_f_en", sdram_f_en, 1'b1);
    check("R9 pci_en", pci_en, 5'b01010);
    check("R9 pci_free_en", pci_free_en, 1'b1);
    check("R9 ref_en", ref_en, 2'b01);
    check("R9 apic_en", apic_en, 1'b1);

    // Second POR: mobile mode, straps 01001
    cfg_b0 = 8'h00; cfg_b1 = 8'h00; cfg_b3 = 8'h00; cfg_b4 = 8'h00;
    por_active = 1'b1;
    strap_fs_pin = 5'b01001; strap_mode_pin = 1'b0;
    cyc(4);
    por_active = 1'b0;
    cyc(3);
    check("R3 hw code second POR", freq_code, 5'b01001);
    check("R10 mobile mode", desktop_mode, 1'b0);
    check("R6 rb_b1 mobile", rb_b1, 8'hC0);
    check("R6 rb_b3 mobile", rb_b3, 8'h80);
    check("R6 rb_b4 mobile", rb_b4, 8'h08);
    finish_run();
  end

endmodule